// File: doc/BRIEF.md
# Exception Entry Controller

This block records the processor state needed when a synchronous exception is taken. In a single clock cycle it accepts either a general exception request or a debug exception request. It decides which handler vector applies, saves the faulting program counter into the matching save register, and updates the status fields: exception mode (EXCM), user mode (UM) and interrupt level. It also latches the cause code and, when one is supplied, the faulting virtual address.

General exceptions taken while exception mode is already set are treated as double exceptions. A parameter selects whether these double exceptions have a dedicated PC save register. Debug exceptions are gated by the current interrupt level. When one is taken, it saves the PC and the complete old status word into a save slot indexed by the configured debug level, and it raises the interrupt level to that value. Software write ports for the status word and for the cause register allow nested scenarios to be prepared.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Reset leaves exception mode set, user mode clear, the interrupt level at all ones, and every save register, `take` and `vec_sel` at zero.
- R2: A general exception taken with exception mode clear saves its PC to `epc1`. `vec_sel` is 0 (kernel) when user mode is clear and 1 (user) when it is set.
- R3: A general exception taken with exception mode set gives `vec_sel` 2 (double). With HAS_DEPC=1 its PC goes to `depc` and `epc1` is left unchanged.
- R4: Every taken general exception writes its cause to `exccause` and sets exception mode. User mode and the interrupt level are left unchanged.
- R5: `excvaddr` takes `gen_vaddr` only on a taken general exception with `gen_has_addr` high. Otherwise it holds its value.
- R6: A debug request is taken only when the interrupt level is strictly below DEBUG_LEVEL. Otherwise it has no effect on any register or on `take`.
- R7: A taken debug exception stores its PC and the old status word in the DEBUG_LEVEL slot. The status word is packed as {excm, um, intlevel[LEVEL_W-1:0]} and both values are read through `rd_level`. The exception writes `dbgcause`, sets the interrupt level to DEBUG_LEVEL, sets exception mode and gives `vec_sel` 3. Slots of other levels read as zero.
- R8: When a debug request that can be taken and a general request arrive in the same cycle, only the debug exception is taken. The general request leaves `exccause`, `excvaddr`, `epc1` and `depc` unchanged.
- R9: `take` is high for exactly the one cycle that follows each clock edge at which a request was accepted. `vec_sel` holds the vector of the most recent accepted exception.
- R10: The software writes to the status word and to `exccause` take effect at the next edge when no exception is accepted in that cycle. They are ignored when an exception is accepted.
- R11: With HAS_DEPC=0 a double exception saves its PC to `epc1`, and `depc` always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | General exception request |
| gen_pc | input | XLEN | PC of the faulting instruction |
| gen_cause | input | CAUSE_W | General exception cause code |
| gen_has_addr | input | 1 | The request carries a faulting address |
| gen_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_pc | input | XLEN | PC for the debug exception |
| dbg_cause | input | DCAUSE_W | Debug cause |
| sw_ps_we | input | 1 | Software write of the status word |
| sw_ps_excm | input | 1 | Exception-mode value to write |
| sw_ps_um | input | 1 | User-mode value to write |
| sw_ps_intlevel | input | LEVEL_W | Interrupt-level value to write |
| sw_cause_we | input | 1 | Software write of `exccause` |
| sw_cause_wdata | input | CAUSE_W | Cause value to write |
| rd_level | input | LEVEL_W | Level whose save slot is read |
| take | output | 1 | One-cycle pulse: an exception was accepted |
| vec_sel | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |
| ps_excm | output | 1 | Exception mode |
| ps_um | output | 1 | User mode |
| ps_intlevel | output | LEVEL_W | Current interrupt level |
| epc1 | output | XLEN | First-level exception PC |
| depc | output | XLEN | Double-exception PC |
| exccause | output | CAUSE_W | Latched cause |
| excvaddr | output | XLEN | Latched faulting address |
| dbgcause | output | DCAUSE_W | Latched debug cause |
| rd_epc | output | XLEN | Saved PC of level `rd_level` |
| rd_eps | output | LEVEL_W+2 | Saved status word of level `rd_level` |

## Verification
A wrong exception-mode bit shows up on the very next accepted general exception, because `vec_sel` switches between the first-level and double vectors and the PC lands in the wrong save register. A corrupted interrupt level shows up on the next debug request, which is either taken or dropped against expectation. That result is visible on `take` one cycle after the request. Status and save-register contents are compared at the ports after every cycle, so a stale or mis-targeted update is seen within one cycle of its cause.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // Vector of a general exception from the current mode bits.
  function automatic vec_e general_vector(input logic excm, input logic um);
    if (excm)    return VEC_DOUBLE;
    else if (um) return VEC_USER;
    else         return VEC_KERNEL;
  endfunction

  // A debug exception may enter only strictly below its own level.
  function automatic logic debug_permitted(input int unsigned cur_level,
                                           input int unsigned dbg_level);
    return cur_level < dbg_level;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int LEVEL_W     = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic               gen_req,
  input  logic               dbg_req,
  input  logic               ps_excm,
  input  logic               ps_um,
  input  logic [LEVEL_W-1:0] ps_intlevel,
  output logic               take_gen,
  output logic               take_dbg,
  output logic               to_double,
  output vec_e               vec_next
);

  logic dbg_ok;

  always_comb begin
    dbg_ok    = dbg_req && debug_permitted(int'(ps_intlevel), DEBUG_LEVEL);
    take_dbg  = dbg_ok;
    take_gen  = gen_req && !dbg_ok;
    to_double = ps_excm;
    if (dbg_ok) vec_next = VEC_DEBUG;
    else        vec_next = general_vector(ps_excm, ps_um);
  end

endmodule

// File: rtl/exc_ps_reg.sv
module exc_ps_reg #(
  parameter int LEVEL_W     = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_gen,
  input  logic               take_dbg,
  input  logic               sw_we,
  input  logic               sw_excm,
  input  logic               sw_um,
  input  logic [LEVEL_W-1:0] sw_intlevel,
  output logic               excm,
  output logic               um,
  output logic [LEVEL_W-1:0] intlevel
);

  localparam logic [LEVEL_W-1:0] DBG_LVL = LEVEL_W'(DEBUG_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excm     <= 1'b1;
      um       <= 1'b0;
      intlevel <= '1;
    end else if (take_dbg) begin
      excm     <= 1'b1;
      intlevel <= DBG_LVL;
    end else if (take_gen) begin
      excm     <= 1'b1;
    end else if (sw_we) begin
      excm     <= sw_excm;
      um       <= sw_um;
      intlevel <= sw_intlevel;
    end
  end

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 4,
  parameter int LEVEL_W     = 4,
  parameter int NUM_LEVELS  = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  localparam int EPS_W      = LEVEL_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_gen,
  input  logic                take_dbg,
  input  logic                to_double,
  input  logic [XLEN-1:0]     gen_pc,
  input  logic [CAUSE_W-1:0]  gen_cause,
  input  logic                gen_has_addr,
  input  logic [XLEN-1:0]     gen_vaddr,
  input  logic [XLEN-1:0]     dbg_pc,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic [EPS_W-1:0]    ps_snapshot,
  input  logic                sw_cause_we,
  input  logic [CAUSE_W-1:0]  sw_cause_wdata,
  input  logic [LEVEL_W-1:0]  rd_level,
  output logic [XLEN-1:0]     epc1,
  output logic [XLEN-1:0]     depc,
  output logic [CAUSE_W-1:0]  exccause,
  output logic [XLEN-1:0]     excvaddr,
  output logic [DCAUSE_W-1:0] dbgcause,
  output logic [XLEN-1:0]     rd_epc,
  output logic [EPS_W-1:0]    rd_eps
);

  logic epc1_we;
  logic [XLEN-1:0]  lvl_epc [2:NUM_LEVELS];
  logic [EPS_W-1:0] lvl_eps [2:NUM_LEVELS];

  // First-level PC is written unless a dedicated double register exists.
  assign epc1_we = take_gen && (!to_double || !HAS_DEPC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc1     <= '0;
      exccause <= '0;
      excvaddr <= '0;
      dbgcause <= '0;
    end else begin
      if (epc1_we) epc1 <= gen_pc;
      if (take_gen) begin
        exccause <= gen_cause;
        if (gen_has_addr) excvaddr <= gen_vaddr;
      end else if (sw_cause_we && !take_dbg) begin
        exccause <= sw_cause_wdata;
      end
      if (take_dbg) dbgcause <= dbg_cause;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                      depc_q <= '0;
        else if (take_gen && to_double)  depc_q <= gen_pc;
      end
      assign depc = depc_q;
    end else begin : g_no_depc
      assign depc = '0;
    end
  endgenerate

  generate
    for (genvar lv = 2; lv <= NUM_LEVELS; lv++) begin : g_level
      if (lv == DEBUG_LEVEL) begin : g_dbg_slot
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            lvl_epc[lv] <= '0;
            lvl_eps[lv] <= '0;
          end else if (take_dbg) begin
            lvl_epc[lv] <= dbg_pc;
            lvl_eps[lv] <= ps_snapshot;
          end
        end
      end else begin : g_idle_slot
        assign lvl_epc[lv] = '0;
        assign lvl_eps[lv] = '0;
      end
    end
  endgenerate

  always_comb begin
    rd_epc = '0;
    rd_eps = '0;
    for (int lv = 2; lv <= NUM_LEVELS; lv++) begin
      if (rd_level == LEVEL_W'(lv)) begin
        rd_epc = lvl_epc[lv];
        rd_eps = lvl_eps[lv];
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 4,
  parameter int LEVEL_W     = 4,
  parameter int NUM_LEVELS  = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  localparam int EPS_W      = LEVEL_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_req,
  input  logic [XLEN-1:0]     gen_pc,
  input  logic [CAUSE_W-1:0]  gen_cause,
  input  logic                gen_has_addr,
  input  logic [XLEN-1:0]     gen_vaddr,
  input  logic                dbg_req,
  input  logic [XLEN-1:0]     dbg_pc,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic                sw_ps_we,
  input  logic                sw_ps_excm,
  input  logic                sw_ps_um,
  input  logic [LEVEL_W-1:0]  sw_ps_intlevel,
  input  logic                sw_cause_we,
  input  logic [CAUSE_W-1:0]  sw_cause_wdata,
  input  logic [LEVEL_W-1:0]  rd_level,
  output logic                take,
  output logic [1:0]          vec_sel,
  output logic                ps_excm,
  output logic                ps_um,
  output logic [LEVEL_W-1:0]  ps_intlevel,
  output logic [XLEN-1:0]     epc1,
  output logic [XLEN-1:0]     depc,
  output logic [CAUSE_W-1:0]  exccause,
  output logic [XLEN-1:0]     excvaddr,
  output logic [DCAUSE_W-1:0] dbgcause,
  output logic [XLEN-1:0]     rd_epc,
  output logic [EPS_W-1:0]    rd_eps
);

  // Named internal events, observed by the bound checker.
  logic take_gen_w;
  logic take_dbg_w;
  logic to_double_w;
  vec_e vec_next_w;
  logic [EPS_W-1:0] ps_snapshot_w;
  vec_e vec_q;

  exc_arbiter #(
    .LEVEL_W     (LEVEL_W),
    .DEBUG_LEVEL (DEBUG_LEVEL)
  ) u_arb (
    .gen_req     (gen_req),
    .dbg_req     (dbg_req),
    .ps_excm     (ps_excm),
    .ps_um       (ps_um),
    .ps_intlevel (ps_intlevel),
    .take_gen    (take_gen_w),
    .take_dbg    (take_dbg_w),
    .to_double   (to_double_w),
    .vec_next    (vec_next_w)
  );

  exc_ps_reg #(
    .LEVEL_W     (LEVEL_W),
    .DEBUG_LEVEL (DEBUG_LEVEL)
  ) u_ps (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_gen    (take_gen_w),
    .take_dbg    (take_dbg_w),
    .sw_we       (sw_ps_we),
    .sw_excm     (sw_ps_excm),
    .sw_um       (sw_ps_um),
    .sw_intlevel (sw_ps_intlevel),
    .excm        (ps_excm),
    .um          (ps_um),
    .intlevel    (ps_intlevel)
  );

  assign ps_snapshot_w = {ps_excm, ps_um, ps_intlevel};

  exc_save_bank #(
    .XLEN        (XLEN),
    .CAUSE_W     (CAUSE_W),
    .DCAUSE_W    (DCAUSE_W),
    .LEVEL_W     (LEVEL_W),
    .NUM_LEVELS  (NUM_LEVELS),
    .DEBUG_LEVEL (DEBUG_LEVEL),
    .HAS_DEPC    (HAS_DEPC)
  ) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .take_gen       (take_gen_w),
    .take_dbg       (take_dbg_w),
    .to_double      (to_double_w),
    .gen_pc         (gen_pc),
    .gen_cause      (gen_cause),
    .gen_has_addr   (gen_has_addr),
    .gen_vaddr      (gen_vaddr),
    .dbg_pc         (dbg_pc),
    .dbg_cause      (dbg_cause),
    .ps_snapshot    (ps_snapshot_w),
    .sw_cause_we    (sw_cause_we),
    .sw_cause_wdata (sw_cause_wdata),
    .rd_level       (rd_level),
    .epc1           (epc1),
    .depc           (depc),
    .exccause       (exccause),
    .excvaddr       (excvaddr),
    .dbgcause       (dbgcause),
    .rd_epc         (rd_epc),
    .rd_eps         (rd_eps)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take  <= 1'b0;
      vec_q <= VEC_KERNEL;
    end else begin
      take <= take_gen_w || take_dbg_w;
      if (take_gen_w || take_dbg_w) vec_q <= vec_next_w;
    end
  end

  assign vec_sel = vec_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int LEVEL_W     = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gen_req,
  input logic               dbg_req,
  input logic [XLEN-1:0]    gen_pc,
  input logic [CAUSE_W-1:0] gen_cause,
  input logic               sw_cause_we,
  input logic               take,
  input logic [1:0]         vec_sel,
  input logic               ps_excm,
  input logic [LEVEL_W-1:0] ps_intlevel,
  input logic [XLEN-1:0]    epc1,
  input logic [CAUSE_W-1:0] exccause,
  input logic               take_gen_w,
  input logic               take_dbg_w
);

  localparam logic [LEVEL_W-1:0] DBG_LVL = LEVEL_W'(DEBUG_LEVEL);

  p_take_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(gen_req || dbg_req));

  p_excm_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ps_excm);

  p_first_level_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen_w && !ps_excm) |=> (epc1 == $past(gen_pc)));

  p_double_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen_w && ps_excm) |=> (take && vec_sel == 2'd2));

  p_debug_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !gen_req && ps_intlevel >= DBG_LVL) |=> !take);

  p_debug_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg_w |=> (ps_intlevel == DBG_LVL && vec_sel == 2'd3));

  p_debug_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && gen_req && ps_intlevel < DBG_LVL) |=> (vec_sel == 2'd3 && $stable(exccause)));

  p_sw_cause_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cause_we && take_gen_w) |=> (exccause == $past(gen_cause)));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN        (XLEN),
  .CAUSE_W     (CAUSE_W),
  .LEVEL_W     (LEVEL_W),
  .DEBUG_LEVEL (DEBUG_LEVEL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_req     (gen_req),
  .dbg_req     (dbg_req),
  .gen_pc      (gen_pc),
  .gen_cause   (gen_cause),
  .sw_cause_we (sw_cause_we),
  .take        (take),
  .vec_sel     (vec_sel),
  .ps_excm     (ps_excm),
  .ps_intlevel (ps_intlevel),
  .epc1        (epc1),
  .exccause    (exccause),
  .take_gen_w  (take_gen_w),
  .take_dbg_w  (take_dbg_w)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CAUSE_W = 6;
  localparam int DCAUSE_W = 4;
  localparam int LEVEL_W = 4;
  localparam int NUM_LEVELS = 7;
  localparam int DBG_LVL = 6;
  localparam int EPS_W = LEVEL_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_req = 0, gen_has_addr = 0, dbg_req = 0;
  logic [XLEN-1:0] gen_pc = '0, gen_vaddr = '0, dbg_pc = '0;
  logic [CAUSE_W-1:0] gen_cause = '0, sw_cause_wdata = '0;
  logic [DCAUSE_W-1:0] dbg_cause = '0;
  logic sw_ps_we = 0, sw_ps_excm = 0, sw_ps_um = 0, sw_cause_we = 0;
  logic [LEVEL_W-1:0] sw_ps_intlevel = '0;
  logic [LEVEL_W-1:0] rd_level = LEVEL_W'(DBG_LVL);

  logic take, ps_excm, ps_um;
  logic [1:0] vec_sel;
  logic [LEVEL_W-1:0] ps_intlevel;
  logic [XLEN-1:0] epc1, depc, excvaddr, rd_epc;
  logic [CAUSE_W-1:0] exccause;
  logic [DCAUSE_W-1:0] dbgcause;
  logic [EPS_W-1:0] rd_eps;

  logic take1, ps_excm1, ps_um1;
  logic [1:0] vec_sel1;
  logic [LEVEL_W-1:0] ps_intlevel1;
  logic [XLEN-1:0] epc1_1, depc1, excvaddr1, rd_epc1;
  logic [CAUSE_W-1:0] exccause1;
  logic [DCAUSE_W-1:0] dbgcause1;
  logic [EPS_W-1:0] rd_eps1;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl #(.HAS_DEPC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_pc(gen_pc), .gen_cause(gen_cause),
    .gen_has_addr(gen_has_addr), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req), .dbg_pc(dbg_pc),
    .dbg_cause(dbg_cause), .sw_ps_we(sw_ps_we), .sw_ps_excm(sw_ps_excm), .sw_ps_um(sw_ps_um),
    .sw_ps_intlevel(sw_ps_intlevel), .sw_cause_we(sw_cause_we), .sw_cause_wdata(sw_cause_wdata),
    .rd_level(rd_level), .take(take), .vec_sel(vec_sel), .ps_excm(ps_excm), .ps_um(ps_um),
    .ps_intlevel(ps_intlevel), .epc1(epc1), .depc(depc), .exccause(exccause),
    .excvaddr(excvaddr), .dbgcause(dbgcause), .rd_epc(rd_epc), .rd_eps(rd_eps));

  exc_entry_ctrl #(.HAS_DEPC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_pc(gen_pc), .gen_cause(gen_cause),
    .gen_has_addr(gen_has_addr), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req), .dbg_pc(dbg_pc),
    .dbg_cause(dbg_cause), .sw_ps_we(sw_ps_we), .sw_ps_excm(sw_ps_excm), .sw_ps_um(sw_ps_um),
    .sw_ps_intlevel(sw_ps_intlevel), .sw_cause_we(sw_cause_we), .sw_cause_wdata(sw_cause_wdata),
    .rd_level(rd_level), .take(take1), .vec_sel(vec_sel1), .ps_excm(ps_excm1), .ps_um(ps_um1),
    .ps_intlevel(ps_intlevel1), .epc1(epc1_1), .depc(depc1), .exccause(exccause1),
    .excvaddr(excvaddr1), .dbgcause(dbgcause1), .rd_epc(rd_epc1), .rd_eps(rd_eps1));

  int n_chk = 0;
  int n_fail = 0;

  // Reference state
  logic m_excm, m_um, m_take;
  logic [1:0] m_vec;
  logic [LEVEL_W-1:0] m_il;
  logic [XLEN-1:0] m_epc1, m_depc, m_vaddr, m_lepc, m1_epc1;
  logic [CAUSE_W-1:0] m_cause;
  logic [DCAUSE_W-1:0] m_dcause;
  logic [EPS_W-1:0] m_eps;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_vector(input logic excm, input logic um);
    return excm ? 2'd2 : (um ? 2'd1 : 2'd0);
  endfunction

  task automatic model_reset();
    m_excm = 1; m_um = 0; m_il = '1; m_take = 0; m_vec = 0;
    m_epc1 = 0; m_depc = 0; m_vaddr = 0; m_lepc = 0; m1_epc1 = 0;
    m_cause = 0; m_dcause = 0; m_eps = 0;
  endtask

  task automatic predict();
    logic dbg_ok;
    dbg_ok = dbg_req && (int'(m_il) < DBG_LVL);
    m_take = dbg_ok || gen_req;
    if (dbg_ok) begin
      m_lepc = dbg_pc; m_eps = {m_excm, m_um, m_il};
      m_il = LEVEL_W'(DBG_LVL); m_excm = 1; m_dcause = dbg_cause; m_vec = 2'd3;
    end else if (gen_req) begin
      m_vec = exp_vector(m_excm, m_um);
      if (gen_has_addr) m_vaddr = gen_vaddr;
      if (m_excm) m_depc = gen_pc;
      else m_epc1 = gen_pc;
      m1_epc1 = gen_pc;
      m_cause = gen_cause; m_excm = 1;
    end else begin
      if (sw_ps_we) begin m_excm = sw_ps_excm; m_um = sw_ps_um; m_il = sw_ps_intlevel; end
      if (sw_cause_we) m_cause = sw_cause_wdata;
    end
  endtask

  task automatic compare_all();
    chk("R9 take", 64'(take), 64'(m_take));
    if (m_take) chk("R9 vec_sel", 64'(vec_sel), 64'(m_vec));
    chk("R4 ps_excm", 64'(ps_excm), 64'(m_excm));
    chk("R4 ps_um", 64'(ps_um), 64'(m_um));
    chk("R7 ps_intlevel", 64'(ps_intlevel), 64'(m_il));
    chk("R2 epc1", 64'(epc1), 64'(m_epc1));
    chk("R3 depc", 64'(depc), 64'(m_depc));
    chk("R4 exccause", 64'(exccause), 64'(m_cause));
    chk("R5 excvaddr", 64'(excvaddr), 64'(m_vaddr));
    chk("R7 dbgcause", 64'(dbgcause), 64'(m_dcause));
    chk("R7 rd_epc", 64'(rd_epc), (int'(rd_level) == DBG_LVL) ? 64'(m_lepc) : 64'd0);
    chk("R7 rd_eps", 64'(rd_eps), (int'(rd_level) == DBG_LVL) ? 64'(m_eps) : 64'd0);
    chk("R11 epc1 no-depc", 64'(epc1_1), 64'(m1_epc1));
    chk("R11 depc zero", 64'(depc1), 64'd0);
  endtask

  task automatic idle_inputs();
    gen_req = 0; gen_has_addr = 0; dbg_req = 0; sw_ps_we = 0; sw_cause_we = 0;
  endtask

  // Called at a negedge with inputs set; returns at the next negedge.
  task automatic step();
    predict();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic set_ps(input logic e, input logic u, input logic [LEVEL_W-1:0] l);
    sw_ps_we = 1; sw_ps_excm = e; sw_ps_um = u; sw_ps_intlevel = l;
    step();
  endtask

  task automatic general(input logic [XLEN-1:0] pc, input logic [CAUSE_W-1:0] c,
                         input logic ha, input logic [XLEN-1:0] va);
    gen_req = 1; gen_pc = pc; gen_cause = c; gen_has_addr = ha; gen_vaddr = va;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 take", 64'(take), 64'd0);
    chk("R1 vec_sel", 64'(vec_sel), 64'd0);
    chk("R1 ps_excm", 64'(ps_excm), 64'd1);
    chk("R1 ps_um", 64'(ps_um), 64'd0);
    chk("R1 ps_intlevel", 64'(ps_intlevel), 64'hF);
    chk("R1 epc1", 64'(epc1), 64'd0);
    chk("R1 exccause", 64'(exccause), 64'd0);
    chk("R1 rd_eps", 64'(rd_eps), 64'd0);

    // R6: debug masked while level is at reset maximum
    dbg_req = 1; dbg_pc = 32'h1000; dbg_cause = 4'h5;
    step();
    chk("R6 masked debug take", 64'(take), 64'd0);

    // R10 + R2: clear mode, then kernel exception
    set_ps(1'b0, 1'b0, 4'd0);
    general(32'h2000_0010, 6'd9, 1'b0, 32'hDEAD_0000);
    chk("R2 kernel vector", 64'(vec_sel), 64'd0);
    // R9: pulse lasts one cycle
    step();
    chk("R9 take dropped", 64'(take), 64'd0);

    // R3 + R5 + R11: nested becomes double
    general(32'h2000_0020, 6'd3, 1'b1, 32'hCAFE_0004);
    chk("R3 double vector", 64'(vec_sel), 64'd2);

    // R2: user vector
    set_ps(1'b0, 1'b1, 4'd2);
    general(32'h3000_0000, 6'd7, 1'b0, 32'h0);
    chk("R2 user vector", 64'(vec_sel), 64'd1);

    // R7: debug at low level, check other slot is zero
    set_ps(1'b0, 1'b1, 4'd1);
    dbg_req = 1; dbg_pc = 32'h4444_0000; dbg_cause = 4'hA;
    step();
    chk("R7 debug vector", 64'(vec_sel), 64'd3);
    rd_level = 4'd3; #1;
    chk("R7 other slot", 64'(rd_epc), 64'd0);
    rd_level = LEVEL_W'(DBG_LVL);

    // R6: level equals debug level -> ignored
    dbg_req = 1; dbg_pc = 32'h5555_0000; dbg_cause = 4'h1;
    step();
    chk("R6 equal level ignored", 64'(take), 64'd0);

    // R8: debug beats general
    set_ps(1'b0, 1'b0, 4'd0);
    dbg_req = 1; dbg_pc = 32'h6666_0000; dbg_cause = 4'h2;
    gen_req = 1; gen_pc = 32'h7777_0000; gen_cause = 6'd33; gen_has_addr = 1; gen_vaddr = 32'h1;
    step();
    chk("R8 debug wins", 64'(vec_sel), 64'd3);

    // R10: software cause write lost when exception accepted
    sw_cause_we = 1; sw_cause_wdata = 6'd60;
    general(32'h8000_0000, 6'd11, 1'b0, 32'h0);
    chk("R10 cause from exception", 64'(exccause), 64'd11);
    sw_cause_we = 1; sw_cause_wdata = 6'd61;
    step();
    chk("R10 cause from software", 64'(exccause), 64'd61);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      gen_req = ($urandom % 3) == 0;
      gen_pc = $urandom; gen_cause = CAUSE_W'($urandom); gen_has_addr = $urandom % 2;
      gen_vaddr = $urandom;
      dbg_req = ($urandom % 5) == 0;
      dbg_pc = $urandom; dbg_cause = DCAUSE_W'($urandom);
      sw_ps_we = ($urandom % 3) == 0;
      sw_ps_excm = ($urandom % 4) == 0; sw_ps_um = $urandom % 2;
      sw_ps_intlevel = LEVEL_W'($urandom % 9);
      sw_cause_we = ($urandom % 6) == 0; sw_cause_wdata = CAUSE_W'($urandom);
      rd_level = ($urandom % 4 == 0) ? LEVEL_W'($urandom) : LEVEL_W'(DBG_LVL);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule